// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Formatter

This unit sits between the decode stage of a 32-bit big-endian core and its 32-bit data port. It takes a memory instruction word together with the values of the two registers it names. It adds the sign-extended 16-bit offset to the base register value and issues a word-aligned request. Byte enables and write data are placed on the byte lanes that match the low address bits. The byte at address offset 0 lives in bits [31:24].

For loads, the addressed byte or halfword is taken from the returned word. It is sign- or zero-extended according to the opcode and handed back with a one-cycle valid strobe in the same cycle the memory signals ready. A halfword or word access that is not naturally aligned issues no request and raises a one-cycle misalignment pulse carrying the faulting address. Only one request is outstanding at a time. While it waits, `op_ready` is low and offered operations are not taken.

Top module: `be_lsu_unit`

## Requirements
- R1: After reset `mem_req`, `ld_valid` and `misalign` are low and `op_ready` is high.
- R2: An accepted, aligned operation raises `mem_req` on the next cycle. `mem_addr` equals base value plus the sign-extended `op_insn[15:0]`, with bits [1:0] cleared.
- R3: The opcode is `op_insn[31:26]`. Loads are 4 (signed byte), 16 (unsigned byte), 7 (signed half), 11 (unsigned half) and 10 (word). Stores are 12 (byte), 3 (half) and 22 (word). Any other opcode produces no request and no misalignment pulse.
- R4: `mem_be[3]` enables offset 0 (bits [31:24]) and `mem_be[0]` enables offset 3. A byte access enables `4'b1000 >> offset`. A halfword uses `4'b1100` at offset 0 and `4'b0011` at offset 2. A word uses `4'b1111`.
- R5: Stores drive `mem_we` high. The store value is the low byte of `src_val` copied to all four lanes, or the low half copied to both halves, or the full word. Loads drive `mem_we` low.
- R6: Load data is the addressed byte or halfword of `mem_rdata`. Signed opcodes sign-extend it to 32 bits and unsigned opcodes zero-extend it. A word load returns `mem_rdata` unchanged.
- R7: `ld_valid` is high exactly in the cycle where a pending load sees `mem_ready`. `ld_dest` is then `op_insn[20:16]` of that load. Stores never raise `ld_valid`.
- R8: A halfword at an odd address, or a word whose address bits [1:0] are non-zero, raises `misalign` for one cycle in the cycle after acceptance, with `fault_addr` equal to the full effective address. No request is issued.
- R9: While a request waits for `mem_ready`, its address, enables, data and direction stay constant and `op_ready` is low. Operations offered meanwhile are dropped. The request ends in the cycle after `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Memory operation offered |
| op_ready | output | 1 | Unit can take an operation |
| op_insn | input | 32 | Instruction word |
| base_sel | output | 5 | Register index of the address base, `op_insn[25:21]` |
| src_sel | output | 5 | Register index of store data or load destination, `op_insn[20:16]` |
| base_val | input | 32 | Value of the base register |
| src_val | input | 32 | Value of the store data register |
| mem_req | output | 1 | Request to the data port |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_be | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_ready | input | 1 | Data port completes the request |
| mem_rdata | input | 32 | Read word from the data port |
| ld_valid | output | 1 | Load result strobe |
| ld_dest | output | 5 | Destination register of the load |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Unaligned access pulse |
| fault_addr | output | 32 | Effective address of the unaligned access |

## Verification
The bench sweeps all eight memory opcodes and two non-memory opcodes across all four address offsets. Both positive and negative offsets are used, so the sign extension of the immediate and each lane position are separated. Three read and store patterns are applied. Their bytes have the top bit set in some lanes and clear in others, which distinguishes sign extension from zero extension and exposes a swapped or mirrored lane. A separate run offers an operation while a request is stalled, to show that the stalled request is unchanged and the offered operation is dropped.

// File: rtl/be_lsu_unit.sv
module be_lsu_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [31:0]   op_insn,
  output logic [4:0]    base_sel,
  output logic [4:0]    src_sel,
  input  logic [AW-1:0] base_val,
  input  logic [31:0]   src_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [4:0]    ld_dest,
  output logic [31:0]   ld_data,
  output logic          misalign,
  output logic [AW-1:0] fault_addr
);
  localparam logic [5:0] OPC_LDB  = 6'd4;
  localparam logic [5:0] OPC_LDBU = 6'd16;
  localparam logic [5:0] OPC_LDH  = 6'd7;
  localparam logic [5:0] OPC_LDHU = 6'd11;
  localparam logic [5:0] OPC_LDW  = 6'd10;
  localparam logic [5:0] OPC_STB  = 6'd12;
  localparam logic [5:0] OPC_STH  = 6'd3;
  localparam logic [5:0] OPC_STW  = 6'd22;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  logic          is_ld, is_st, sgn;
  logic [1:0]    sz;
  logic [AW-1:0] ea;
  logic          bad;
  logic [3:0]    be_c;
  logic [31:0]   wd_c;

  logic          pend, p_we, p_sgn;
  logic [1:0]    p_sz, p_off;
  logic [AW-1:0] p_addr;
  logic [3:0]    p_be;
  logic [31:0]   p_wd;
  logic [4:0]    p_dest;
  logic          mis_q;
  logic [AW-1:0] fault_q;

  assign base_sel = op_insn[25:21];
  assign src_sel  = op_insn[20:16];
  assign ea       = base_val + AW'($signed(op_insn[15:0]));

  always_comb begin
    is_ld = 1'b0;
    is_st = 1'b0;
    sgn   = 1'b0;
    sz    = SZ_W;
    unique case (op_insn[31:26])
      OPC_LDB:  begin is_ld = 1'b1; sgn = 1'b1; sz = SZ_B; end
      OPC_LDBU: begin is_ld = 1'b1;             sz = SZ_B; end
      OPC_LDH:  begin is_ld = 1'b1; sgn = 1'b1; sz = SZ_H; end
      OPC_LDHU: begin is_ld = 1'b1;             sz = SZ_H; end
      OPC_LDW:  begin is_ld = 1'b1;             sz = SZ_W; end
      OPC_STB:  begin is_st = 1'b1;             sz = SZ_B; end
      OPC_STH:  begin is_st = 1'b1;             sz = SZ_H; end
      OPC_STW:  begin is_st = 1'b1;             sz = SZ_W; end
      default:  ;
    endcase
  end

  assign bad = (sz == SZ_H && ea[0]) || (sz == SZ_W && ea[1:0] != 2'b00);

  always_comb begin
    unique case (sz)
      SZ_B:    begin be_c = 4'b1000 >> ea[1:0];             wd_c = {4{src_val[7:0]}};  end
      SZ_H:    begin be_c = ea[1] ? 4'b0011 : 4'b1100;      wd_c = {2{src_val[15:0]}}; end
      default: begin be_c = 4'b1111;                        wd_c = src_val;            end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_we    <= 1'b0;
      p_sgn   <= 1'b0;
      p_sz    <= SZ_W;
      p_off   <= 2'b00;
      p_addr  <= '0;
      p_be    <= 4'b0000;
      p_wd    <= '0;
      p_dest  <= '0;
      mis_q   <= 1'b0;
      fault_q <= '0;
    end else begin
      mis_q <= 1'b0;
      if (pend && mem_ready) pend <= 1'b0;
      if (op_valid && !pend && (is_ld || is_st)) begin
        if (bad) begin
          mis_q   <= 1'b1;
          fault_q <= ea;
        end else begin
          pend   <= 1'b1;
          p_we   <= is_st;
          p_sgn  <= sgn;
          p_sz   <= sz;
          p_off  <= ea[1:0];
          p_addr <= {ea[AW-1:2], 2'b00};
          p_be   <= be_c;
          p_wd   <= wd_c;
          p_dest <= op_insn[20:16];
        end
      end
    end
  end

  logic [7:0]  rd_b;
  logic [15:0] rd_h;
  logic [31:0] rd_sh;

  assign rd_sh = mem_rdata >> {~p_off, 3'b000};
  assign rd_b  = rd_sh[7:0];
  assign rd_h  = p_off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    unique case (p_sz)
      SZ_B:    ld_data = {{24{p_sgn & rd_b[7]}}, rd_b};
      SZ_H:    ld_data = {{16{p_sgn & rd_h[15]}}, rd_h};
      default: ld_data = mem_rdata;
    endcase
  end

  assign op_ready   = !pend;
  assign mem_req    = pend;
  assign mem_we     = p_we;
  assign mem_addr   = p_addr;
  assign mem_be     = p_be;
  assign mem_wdata  = p_wd;
  assign ld_valid   = pend && !p_we && mem_ready;
  assign ld_dest    = p_dest;
  assign misalign   = mis_q;
  assign fault_addr = fault_q;
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic          ld_valid,
  input logic          misalign
);
  p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                 mem_be == 4'b0011 || mem_be == 4'b1111));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) &&
                              $stable(mem_wdata) && $stable(mem_we));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req);

  p_ldv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> mem_req && mem_ready && !mem_we);

  p_mis_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_req);
endmodule

bind be_lsu_unit be_lsu_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .ld_valid(ld_valid), .misalign(misalign)
);

// File: tb/be_lsu_unit_tb_top.sv
`timescale 1ns/1ps
module be_lsu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] op_insn = '0;
  logic [4:0]  base_sel, src_sel;
  logic [31:0] base_val = '0;
  logic [31:0] src_val = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [4:0]  ld_dest;
  logic [31:0] ld_data;
  logic        misalign;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  be_lsu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_insn(op_insn), .base_sel(base_sel), .src_sel(src_sel),
    .base_val(base_val), .src_val(src_val), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_dest(ld_dest), .ld_data(ld_data), .misalign(misalign),
    .fault_addr(fault_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_op(input logic [5:0] opc, input logic [31:0] base,
                        input logic [15:0] imm, input logic [31:0] src,
                        input logic [31:0] rdat);
    logic ld, st, sg;
    int sz;
    logic [31:0] ea, exp_d;
    logic [1:0] off;
    logic [3:0] exp_be;
    logic [31:0] exp_wd;
    logic [7:0] b;
    logic [15:0] h;
    ld = (opc == 6'd4 || opc == 6'd16 || opc == 6'd7 || opc == 6'd11 || opc == 6'd10);
    st = (opc == 6'd12 || opc == 6'd3 || opc == 6'd22);
    sg = (opc == 6'd4 || opc == 6'd7);
    sz = (opc == 6'd4 || opc == 6'd16 || opc == 6'd12) ? 1 :
         (opc == 6'd7 || opc == 6'd11 || opc == 6'd3) ? 2 : 4;
    ea = base + {{16{imm[15]}}, imm};
    off = ea[1:0];
    op_insn = {opc, 5'd3, 5'd9, imm};
    base_val = base;
    src_val = src;
    op_valid = 1'b1;
    @(posedge clk); #1;
    op_valid = 1'b0;
    if (!ld && !st) begin
      chk("R3 other opcode no req", {63'd0, mem_req}, 64'd0);
      chk("R3 other opcode no misalign", {63'd0, misalign}, 64'd0);
      return;
    end
    if ((sz == 2 && off[0]) || (sz == 4 && off != 2'd0)) begin
      chk("R8 misalign pulse", {62'd0, misalign, mem_req}, 64'd2);
      chk("R8 fault address", {32'd0, fault_addr}, {32'd0, ea});
      @(posedge clk); #1;
      chk("R8 pulse one cycle", {63'd0, misalign}, 64'd0);
      return;
    end
    exp_be = (sz == 1) ? (4'b1000 >> off) : (sz == 2) ? (off[1] ? 4'b0011 : 4'b1100) : 4'b1111;
    exp_wd = (sz == 1) ? {4{src[7:0]}} : (sz == 2) ? {2{src[15:0]}} : src;
    chk("R2 request and address", {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, ea & 32'hFFFF_FFFC});
    chk("R4 byte enables", {60'd0, mem_be}, {60'd0, exp_be});
    chk("R5 direction", {63'd0, mem_we}, {63'd0, st});
    if (st) chk("R5 store lanes", {32'd0, mem_wdata}, {32'd0, exp_wd});
    @(posedge clk); #1;
    chk("R9 stall hold", {27'd0, op_ready, mem_req, mem_be, mem_addr}, {27'd0, 1'b0, 1'b1, exp_be, ea & 32'hFFFF_FFFC});
    mem_rdata = rdat;
    mem_ready = 1'b1;
    #1;
    b = 8'((rdat >> (8 * (3 - off))) & 32'hFF);
    h = 16'((rdat >> (16 * (1 - off[1]))) & 32'hFFFF);
    exp_d = (sz == 1) ? (sg ? {{24{b[7]}}, b} : {24'd0, b}) :
            (sz == 2) ? (sg ? {{16{h[15]}}, h} : {16'd0, h}) : rdat;
    chk("R7 load strobe", {63'd0, ld_valid}, {63'd0, ld});
    if (ld) begin
      chk("R6 load data", {32'd0, ld_data}, {32'd0, exp_d});
      chk("R7 load dest", {59'd0, ld_dest}, 64'd9);
    end
    @(posedge clk); #1;
    mem_ready = 1'b0;
    chk("R9 request ends", {62'd0, mem_req, ld_valid}, 64'd0);
  endtask

  initial begin
    logic [5:0]  ops [10];
    logic [31:0] pats [3];
    ops[0] = 6'd4;  ops[1] = 6'd16; ops[2] = 6'd7;  ops[3] = 6'd11; ops[4] = 6'd10;
    ops[5] = 6'd12; ops[6] = 6'd3;  ops[7] = 6'd22; ops[8] = 6'd13; ops[9] = 6'd45;
    pats[0] = 32'h80FF_7F01; pats[1] = 32'h7F01_80FE; pats[2] = 32'hA5C3_E10F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {60'd0, mem_req, ld_valid, misalign, op_ready}, 64'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int o = 0; o < 10; o++)
      for (int f = 0; f < 4; f++)
        for (int p = 0; p < 3; p++)
          run_op(ops[o], 32'h1234_0000 + 32'(p) * 32'h100,
                 (p == 2) ? (16'hFFF0 | 16'(f)) : 16'(f),
                 pats[(p + 1) % 3], pats[p]);

    op_insn = {6'd22, 5'd3, 5'd9, 16'h0008};
    base_val = 32'h0000_4000;
    src_val = 32'hDEAD_BEEF;
    op_valid = 1'b1;
    @(posedge clk); #1;
    op_insn = {6'd10, 5'd3, 5'd9, 16'h0040};
    @(posedge clk); #1;
    op_valid = 1'b0;
    chk("R9 offered op dropped", {31'd0, mem_we, mem_addr}, {31'd0, 1'b1, 32'h0000_4008});
    mem_ready = 1'b1;
    @(posedge clk); #1;
    mem_ready = 1'b0;
    chk("R9 no second request", {63'd0, mem_req}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule